// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

This block is the in-order retirement queue of an out-of-order core. Instructions take a slot at issue time, in program order, and receive an index that travels with them through execution. Execution units return results out of order on a writeback port that carries the slot index, the result value and a fault flag. Each cycle the block offers a commit group: the completed entries at the oldest end of the queue, in order, presented on per-slot commit lanes that drive register-file write ports and a store commit port.

The size of a commit group is bounded by the lane count, by the number of register-file write ports and by the store commit bandwidth. When two entries in one group write the same register, only the youngest of them raises its write enable. A fault recorded at writeback is only acted on when the faulting entry is the oldest one. At that point the block reports the fault with the slot index and empties the whole queue. A branch-mispredict input names the mispredicted branch's slot and discards every younger entry in the same cycle.

Top module: `rob_multi_retire`

## Requirements
- R1: Allocation is accepted when `alloc_valid` is high and `alloc_ready` is high. The accepted entry takes slot `alloc_idx`, and `alloc_idx` then advances by one, modulo DEPTH, for the next allocation.
- R2: An entry whose result has not been written back is never offered on a commit lane, and neither is any entry behind it.
- R3: Commit lanes carry only an unbroken run of completed entries starting at the oldest entry. Lane 0 is the oldest, so `commit_valid` is always a contiguous group of low bits. A completed entry behind a pending one waits.
- R4: A commit group holds at most MAX_RETIRE entries, at most RF_PORTS register-writing entries and at most ST_PORTS store entries. The first entry that would exceed a limit ends the group. `commit_st_we[i]` marks a store lane (allocation kind 1), and `commit_rf_we[i]` marks a register write.
- R5: If several register-writing entries in one group name the same destination, only the youngest of them asserts `commit_rf_we`. The others still retire, with `commit_valid` high.
- R6: An entry that carries a fault ends a commit group. Older completed entries in front of it still commit in that cycle.
- R7: When the oldest entry is completed and carries a fault, no lane commits. `exc_valid` and `flush` are high for that cycle and `exc_idx` gives the entry's slot. After the next edge the buffer is empty and allocation restarts at slot 0. Entries younger than the faulting one are never committed.
- R8: When `mispred_valid` is high with slot `mispred_idx`, every entry younger than that slot is discarded, and the next allocation goes to `mispred_idx`+1. In that same cycle, only the branch entry and entries older than it may commit. Any allocation request in that cycle is dropped.
- R9: `alloc_ready` is low while DEPTH entries are held, and an allocation request made then is refused and leaves `alloc_idx` unchanged. `empty` is high when no entries are held.
- R10: After reset the buffer is empty, `alloc_ready` is high, `alloc_idx` is 0, and no commit lane or fault output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_kind | input | 1 | 0 = register write, 1 = store |
| alloc_dest | input | DEST_W | Destination register or store tag |
| alloc_ready | output | 1 | Buffer not full |
| alloc_idx | output | IDX_W | Slot that the next allocation takes |
| wb_valid | input | 1 | Writeback strobe |
| wb_idx | input | IDX_W | Slot being completed |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Execution raised a fault |
| mispred_valid | input | 1 | Branch mispredict strobe |
| mispred_idx | input | IDX_W | Slot of the mispredicted branch |
| commit_valid | output | MAX_RETIRE | Lane retires an entry this cycle |
| commit_rf_we | output | MAX_RETIRE | Lane writes the register file |
| commit_st_we | output | MAX_RETIRE | Lane commits a store |
| commit_dest | output | MAX_RETIRE*DEST_W | Per-lane destination, lane i at bits i*DEST_W |
| commit_value | output | MAX_RETIRE*DATA_W | Per-lane value, lane i at bits i*DATA_W |
| exc_valid | output | 1 | Oldest entry faulted |
| exc_idx | output | IDX_W | Slot of the faulting entry |
| flush | output | 1 | Whole buffer discarded this cycle |
| empty | output | 1 | No entries held |

## Verification
The interaction that matters most is a commit group being offered in the same cycle as a branch mispredict. Retirement then has to be cut at the branch slot, while the count and tail are rebuilt from the branch position less the entries just retired. The bench provokes this by allocating five entries and completing the four youngest first. It then completes the oldest entry, so that a three-entry group is on the lanes, and raises the mispredict for the second slot in that same cycle. It judges the result by the lanes shrinking to the two oldest entries, by the buffer reading empty after the edge, and by the next allocation slot being the one after the branch.

// File: rtl/rob_pkg.sv
package rob_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned DEST_W = 5;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [DEST_W-1:0] dest_t;

    typedef enum logic {
        STAT_PENDING = 1'b0,
        STAT_DONE    = 1'b1
    } stat_e;

    typedef enum logic {
        KIND_REG   = 1'b0,
        KIND_STORE = 1'b1
    } kind_e;

    typedef struct packed {
        kind_e kind;
        dest_t dest;
        data_t value;
        stat_e stat;
        logic  fault;
    } entry_t;

    // an entry that may join a commit group on its own merits
    function automatic logic entry_ready(entry_t e);
        return (e.stat == STAT_DONE) && !e.fault;
    endfunction

    // two register-writing entries aimed at the same destination
    function automatic logic same_reg(entry_t a, entry_t b);
        return (a.kind == KIND_REG) && (b.kind == KIND_REG) && (a.dest == b.dest);
    endfunction

endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store
    import rob_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MAX_RET = 4,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_we,
    input  logic [IDX_W-1:0] alloc_slot,
    input  kind_e            alloc_kind,
    input  dest_t            alloc_dest,
    input  logic             wb_we,
    input  logic [IDX_W-1:0] wb_slot,
    input  data_t            wb_value,
    input  logic             wb_fault,
    input  logic [IDX_W-1:0] head,
    output entry_t           win [MAX_RET]
);

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i].kind  <= KIND_REG;
                mem[i].dest  <= '0;
                mem[i].value <= '0;
                mem[i].stat  <= STAT_PENDING;
                mem[i].fault <= 1'b0;
            end
        end else begin
            if (wb_we) begin
                mem[wb_slot].value <= wb_value;
                mem[wb_slot].stat  <= STAT_DONE;
                mem[wb_slot].fault <= wb_fault;
            end
            // a fresh allocation overrides any stale writeback to the slot
            if (alloc_we) begin
                mem[alloc_slot].kind  <= alloc_kind;
                mem[alloc_slot].dest  <= alloc_dest;
                mem[alloc_slot].value <= '0;
                mem[alloc_slot].stat  <= STAT_PENDING;
                mem[alloc_slot].fault <= 1'b0;
            end
        end
    end

    // window of the oldest MAX_RET slots
    for (genvar g = 0; g < MAX_RET; g++) begin : g_win
        logic [IDX_W-1:0] slot;
        assign slot   = head + IDX_W'(g);
        assign win[g] = mem[slot];
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int MAX_RET  = 4,
    parameter int RF_PORTS = 3,
    parameter int ST_PORTS = 1,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NRET_W  = $clog2(MAX_RET + 1)
) (
    input  entry_t             win [MAX_RET],
    input  logic [CNT_W-1:0]   held,
    input  logic [CNT_W-1:0]   limit,
    output logic [MAX_RET-1:0] take,
    output logic [NRET_W-1:0]  nret,
    output logic               head_fault
);

    int  rf_used;
    int  st_used;
    logic run;

    always_comb begin
        take    = '0;
        nret    = '0;
        rf_used = 0;
        st_used = 0;
        run     = 1'b1;
        for (int i = 0; i < MAX_RET; i++) begin
            if (run && (i < int'(limit)) && entry_ready(win[i])) begin
                if (win[i].kind == KIND_STORE) begin
                    if (st_used < ST_PORTS) begin
                        take[i] = 1'b1;
                        st_used = st_used + 1;
                    end else begin
                        run = 1'b0;
                    end
                end else begin
                    if (rf_used < RF_PORTS) begin
                        take[i] = 1'b1;
                        rf_used = rf_used + 1;
                    end else begin
                        run = 1'b0;
                    end
                end
            end else begin
                run = 1'b0;
            end
            if (take[i]) begin
                nret = nret + NRET_W'(1);
            end
        end
    end

    assign head_fault = (held != '0) && (win[0].stat == STAT_DONE) && win[0].fault;

endmodule

// File: rtl/rob_commit_merge.sv
module rob_commit_merge
    import rob_pkg::*;
#(
    parameter int MAX_RET = 4
) (
    input  entry_t             win [MAX_RET],
    input  logic [MAX_RET-1:0] take,
    output logic [MAX_RET-1:0] rf_we,
    output logic [MAX_RET-1:0] st_we
);

    logic [MAX_RET-1:0] shadowed;

    // a register write is dropped if a younger lane of the group overwrites it
    always_comb begin
        shadowed = '0;
        for (int i = 0; i < MAX_RET; i++) begin
            for (int j = i + 1; j < MAX_RET; j++) begin
                if (take[j] && same_reg(win[i], win[j])) begin
                    shadowed[i] = 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < MAX_RET; g++) begin : g_we
        assign rf_we[g] = take[g] && (win[g].kind == KIND_REG) && !shadowed[g];
        assign st_we[g] = take[g] && (win[g].kind == KIND_STORE);
    end

endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH   = 8,
    parameter int MAX_RET = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int NRET_W = $clog2(MAX_RET + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_fire,
    input  logic [NRET_W-1:0] nret,
    input  logic              flush_all,
    input  logic              cut_valid,
    input  logic [IDX_W-1:0]  cut_idx,
    input  logic [CNT_W-1:0]  cut_keep,
    output logic [IDX_W-1:0]  head,
    output logic [IDX_W-1:0]  tail,
    output logic [CNT_W-1:0]  held
);

    logic [IDX_W-1:0] head_n;
    logic [IDX_W-1:0] tail_n;
    logic [CNT_W-1:0] held_n;

    always_comb begin
        head_n = head + IDX_W'(nret);
        tail_n = tail;
        held_n = held - CNT_W'(nret);
        if (flush_all) begin
            head_n = '0;
            tail_n = '0;
            held_n = '0;
        end else if (cut_valid) begin
            tail_n = cut_idx + IDX_W'(1);
            held_n = cut_keep - CNT_W'(nret);
        end else if (alloc_fire) begin
            tail_n = tail + IDX_W'(1);
            held_n = held - CNT_W'(nret) + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            held <= '0;
        end else begin
            head <= head_n;
            tail <= tail_n;
            held <= held_n;
        end
    end

endmodule

// File: rtl/rob_multi_retire.sv
module rob_multi_retire
    import rob_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int MAX_RET  = 4,
    parameter int RF_PORTS = 3,
    parameter int ST_PORTS = 1,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NRET_W  = $clog2(MAX_RET + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_valid,
    input  logic                        alloc_kind,
    input  logic [DEST_W-1:0]           alloc_dest,
    output logic                        alloc_ready,
    output logic [IDX_W-1:0]            alloc_idx,
    input  logic                        wb_valid,
    input  logic [IDX_W-1:0]            wb_idx,
    input  logic [DATA_W-1:0]           wb_value,
    input  logic                        wb_fault,
    input  logic                        mispred_valid,
    input  logic [IDX_W-1:0]            mispred_idx,
    output logic [MAX_RET-1:0]          commit_valid,
    output logic [MAX_RET-1:0]          commit_rf_we,
    output logic [MAX_RET-1:0]          commit_st_we,
    output logic [MAX_RET*DEST_W-1:0]   commit_dest,
    output logic [MAX_RET*DATA_W-1:0]   commit_value,
    output logic                        exc_valid,
    output logic [IDX_W-1:0]            exc_idx,
    output logic                        flush,
    output logic                        empty
);

    logic [IDX_W-1:0]   head;
    logic [IDX_W-1:0]   tail;
    logic [CNT_W-1:0]   held;
    logic [CNT_W-1:0]   keep;
    logic [CNT_W-1:0]   limit;
    logic [IDX_W-1:0]   cut_off;
    logic [MAX_RET-1:0] take;
    logic [NRET_W-1:0]  nret;
    logic               head_fault;
    logic               full;
    logic               alloc_fire;
    kind_e              kind_in;
    entry_t             win [MAX_RET];

    assign full       = (held == CNT_W'(DEPTH));
    assign alloc_fire = alloc_valid && !full && !mispred_valid && !head_fault;
    assign kind_in    = alloc_kind ? KIND_STORE : KIND_REG;

    // entries from the head up to and including the mispredicted branch
    assign cut_off = mispred_idx - head;
    assign keep    = CNT_W'(cut_off) + CNT_W'(1);
    assign limit   = mispred_valid ? keep : held;

    rob_entry_store #(
        .DEPTH   (DEPTH),
        .MAX_RET (MAX_RET)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .alloc_we   (alloc_fire),
        .alloc_slot (tail),
        .alloc_kind (kind_in),
        .alloc_dest (alloc_dest),
        .wb_we      (wb_valid),
        .wb_slot    (wb_idx),
        .wb_value   (wb_value),
        .wb_fault   (wb_fault),
        .head       (head),
        .win        (win)
    );

    rob_retire_sel #(
        .DEPTH    (DEPTH),
        .MAX_RET  (MAX_RET),
        .RF_PORTS (RF_PORTS),
        .ST_PORTS (ST_PORTS)
    ) u_sel (
        .win        (win),
        .held       (held),
        .limit      (limit),
        .take       (take),
        .nret       (nret),
        .head_fault (head_fault)
    );

    rob_commit_merge #(
        .MAX_RET (MAX_RET)
    ) u_merge (
        .win   (win),
        .take  (take),
        .rf_we (commit_rf_we),
        .st_we (commit_st_we)
    );

    rob_ptr_ctrl #(
        .DEPTH   (DEPTH),
        .MAX_RET (MAX_RET)
    ) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .nret       (nret),
        .flush_all  (head_fault),
        .cut_valid  (mispred_valid),
        .cut_idx    (mispred_idx),
        .cut_keep   (keep),
        .head       (head),
        .tail       (tail),
        .held       (held)
    );

    for (genvar g = 0; g < MAX_RET; g++) begin : g_lane
        assign commit_dest[g*DEST_W +: DEST_W]  = win[g].dest;
        assign commit_value[g*DATA_W +: DATA_W] = win[g].value;
    end

    assign commit_valid = take;
    assign exc_valid    = head_fault;
    assign exc_idx      = head;
    assign flush        = head_fault;
    assign empty        = (held == '0);
    assign alloc_ready  = !full;
    assign alloc_idx    = tail;

endmodule

// File: rtl/rob_multi_retire_chk.sv
module rob_multi_retire_chk
    import rob_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int MAX_RET  = 4,
    parameter int RF_PORTS = 3,
    parameter int ST_PORTS = 1,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      alloc_valid,
    input logic                      alloc_ready,
    input logic [IDX_W-1:0]          alloc_idx,
    input logic                      mispred_valid,
    input logic [IDX_W-1:0]          mispred_idx,
    input logic [MAX_RET-1:0]        commit_valid,
    input logic [MAX_RET-1:0]        commit_rf_we,
    input logic [MAX_RET-1:0]        commit_st_we,
    input logic [MAX_RET*DEST_W-1:0] commit_dest,
    input logic                      exc_valid,
    input logic                      empty
);

    logic [IDX_W-1:0] alloc_next;
    logic [IDX_W-1:0] cut_next;
    logic [MAX_RET-1:0] cv_plus;

    assign alloc_next = alloc_idx + IDX_W'(1);
    assign cut_next   = mispred_idx + IDX_W'(1);
    assign cv_plus    = commit_valid + MAX_RET'(1);

    // R1: an accepted allocation advances the slot pointer by one
    p_alloc_advance_r1: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready && !mispred_valid && !exc_valid)
        |=> (alloc_idx == $past(alloc_next)));

    // R2: nothing retires from an empty buffer
    p_empty_no_commit_r2: assert property (@(posedge clk) disable iff (rst)
        empty |-> (commit_valid == '0));

    // R3: lanes form a contiguous run from lane 0
    p_commit_contig_r3: assert property (@(posedge clk) disable iff (rst)
        ((cv_plus & commit_valid) == '0));

    // R4: port limits per group
    p_rf_ports_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(commit_valid & ~commit_st_we) <= RF_PORTS));

    p_st_ports_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(commit_st_we) <= ST_PORTS));

    // R7: a fault at the head blocks commit and empties the buffer
    p_fault_no_commit_r7: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (commit_valid == '0));

    p_fault_empties_r7: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (empty && (alloc_idx == '0)));

    // R8: mispredict moves the allocation slot to just past the branch
    p_mispred_tail_r8: assert property (@(posedge clk) disable iff (rst)
        (mispred_valid && !exc_valid) |=> (alloc_idx == $past(cut_next)));

    // R9: a refused allocation leaves the slot pointer alone
    p_full_refuse_r9: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_ready && !mispred_valid && !exc_valid)
        |=> $stable(alloc_idx));

    // R5: at most one write enable per destination within a group
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < MAX_RET; i++) begin
                for (int j = i + 1; j < MAX_RET; j++) begin
                    if (commit_rf_we[i] && commit_rf_we[j]) begin
                        a_merge_unique_r5: assert (commit_dest[i*DEST_W +: DEST_W]
                                                   != commit_dest[j*DEST_W +: DEST_W])
                            else $error("duplicate register write in one group");
                    end
                end
            end
        end
    end

endmodule

bind rob_multi_retire rob_multi_retire_chk #(
    .DEPTH    (DEPTH),
    .MAX_RET  (MAX_RET),
    .RF_PORTS (RF_PORTS),
    .ST_PORTS (ST_PORTS)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .alloc_valid   (alloc_valid),
    .alloc_ready   (alloc_ready),
    .alloc_idx     (alloc_idx),
    .mispred_valid (mispred_valid),
    .mispred_idx   (mispred_idx),
    .commit_valid  (commit_valid),
    .commit_rf_we  (commit_rf_we),
    .commit_st_we  (commit_st_we),
    .commit_dest   (commit_dest),
    .exc_valid     (exc_valid),
    .empty         (empty)
);

// File: tb/rob_multi_retire_tb.sv
`timescale 1ns/100ps
module rob_multi_retire_tb_top;
    import rob_pkg::*;

    localparam int DEPTH    = 8;
    localparam int MAX_RET  = 4;
    localparam int RF_PORTS = 3;
    localparam int ST_PORTS = 1;
    localparam int IDX_W    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic                        alloc_valid = 1'b0;
    logic                        alloc_kind  = 1'b0;
    logic [DEST_W-1:0]           alloc_dest  = '0;
    logic                        alloc_ready;
    logic [IDX_W-1:0]            alloc_idx;
    logic                        wb_valid = 1'b0;
    logic [IDX_W-1:0]            wb_idx   = '0;
    logic [DATA_W-1:0]           wb_value = '0;
    logic                        wb_fault = 1'b0;
    logic                        mispred_valid = 1'b0;
    logic [IDX_W-1:0]            mispred_idx   = '0;
    logic [MAX_RET-1:0]          commit_valid;
    logic [MAX_RET-1:0]          commit_rf_we;
    logic [MAX_RET-1:0]          commit_st_we;
    logic [MAX_RET*DEST_W-1:0]   commit_dest;
    logic [MAX_RET*DATA_W-1:0]   commit_value;
    logic                        exc_valid;
    logic [IDX_W-1:0]            exc_idx;
    logic                        flush;
    logic                        empty;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    rob_multi_retire #(
        .DEPTH(DEPTH), .MAX_RET(MAX_RET), .RF_PORTS(RF_PORTS), .ST_PORTS(ST_PORTS)
    ) dut_i (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_value(wb_value), .wb_fault(wb_fault),
        .mispred_valid(mispred_valid), .mispred_idx(mispred_idx),
        .commit_valid(commit_valid), .commit_rf_we(commit_rf_we),
        .commit_st_we(commit_st_we), .commit_dest(commit_dest),
        .commit_value(commit_value), .exc_valid(exc_valid), .exc_idx(exc_idx),
        .flush(flush), .empty(empty)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #0.5;
        alloc_valid   = 1'b0;
        wb_valid      = 1'b0;
        wb_fault      = 1'b0;
        mispred_valid = 1'b0;
        #0.5;
    endtask

    task automatic alloc(input logic kind, input logic [DEST_W-1:0] dest);
        alloc_valid = 1'b1;
        alloc_kind  = kind;
        alloc_dest  = dest;
        tick();
    endtask

    task automatic wb(input int idx, input logic [DATA_W-1:0] val, input logic fault);
        wb_valid = 1'b1;
        wb_idx   = IDX_W'(idx);
        wb_value = val;
        wb_fault = fault;
        tick();
    endtask

    function automatic logic [DEST_W-1:0] lane_dest(input int i);
        return commit_dest[i*DEST_W +: DEST_W];
    endfunction

    function automatic logic [DATA_W-1:0] lane_val(input int i);
        return commit_value[i*DATA_W +: DATA_W];
    endfunction

    task automatic t_reset();
        chk("R10", "empty", empty, 1);
        chk("R10", "alloc_ready", alloc_ready, 1);
        chk("R10", "alloc_idx", alloc_idx, 0);
        chk("R10", "commit_valid", commit_valid, 0);
        chk("R10", "exc_valid", exc_valid, 0);
    endtask

    task automatic t_order();
        for (int k = 0; k < 4; k++) begin
            chk("R1", "alloc_idx", alloc_idx, k);
            alloc(1'b0, DEST_W'(k + 1));
        end
        chk("R2", "no commit while pending", commit_valid, 0);
        chk("R9", "not empty", empty, 0);
        wb(2, 32'h22, 1'b0);
        wb(3, 32'h33, 1'b0);
        chk("R3", "head pending blocks younger", commit_valid, 0);
        wb(0, 32'h10, 1'b0);
        chk("R3", "run stops at pending", commit_valid, 4'b0001);
        chk("R3", "lane0 value", lane_val(0), 32'h10);
        chk("R3", "lane0 dest", lane_dest(0), 1);
        tick();
        chk("R2", "pending head", commit_valid, 0);
        wb(1, 32'h11, 1'b0);
        chk("R3", "three left", commit_valid, 4'b0111);
        chk("R3", "lane2 value", lane_val(2), 32'h33);
        chk("R3", "lane1 dest", lane_dest(1), 3);
        tick();
        chk("R3", "drained", empty, 1);
    endtask

    task automatic t_ports();
        // head = 4
        for (int k = 0; k < 4; k++) alloc(1'b0, DEST_W'(5 + k));
        wb(7, 32'h7, 1'b0);
        wb(6, 32'h6, 1'b0);
        wb(5, 32'h5, 1'b0);
        wb(4, 32'h4, 1'b0);
        chk("R4", "rf port cap", commit_valid, 4'b0111);
        chk("R4", "rf we", commit_rf_we, 4'b0111);
        tick();
        chk("R4", "remainder", commit_valid, 4'b0001);
        chk("R4", "remainder dest", lane_dest(0), 8);
        tick();
        chk("R4", "empty", empty, 1);
        // head = 0: two stores then a register write
        alloc(1'b1, 5'd0);
        alloc(1'b1, 5'd1);
        alloc(1'b0, 5'd9);
        wb(2, 32'h92, 1'b0);
        wb(1, 32'h91, 1'b0);
        wb(0, 32'h90, 1'b0);
        chk("R4", "store cap", commit_valid, 4'b0001);
        chk("R4", "store we", commit_st_we, 4'b0001);
        tick();
        chk("R4", "store+reg", commit_valid, 4'b0011);
        chk("R4", "store we 2", commit_st_we, 4'b0001);
        chk("R4", "rf we 2", commit_rf_we, 4'b0010);
        tick();
        chk("R4", "empty 2", empty, 1);
    endtask

    task automatic t_merge();
        // head = 3
        alloc(1'b0, 5'd3);
        alloc(1'b0, 5'd3);
        alloc(1'b0, 5'd4);
        wb(5, 32'hC, 1'b0);
        wb(4, 32'hB, 1'b0);
        wb(3, 32'hA, 1'b0);
        chk("R5", "all retire", commit_valid, 4'b0111);
        chk("R5", "youngest writes", commit_rf_we, 4'b0110);
        chk("R5", "lane1 dest", lane_dest(1), 3);
        chk("R5", "lane1 value", lane_val(1), 32'hB);
        tick();
        chk("R5", "empty", empty, 1);
    endtask

    task automatic t_fault();
        // head = 6, slots 6,7,0
        alloc(1'b0, 5'd10);
        alloc(1'b0, 5'd11);
        alloc(1'b0, 5'd12);
        wb(0, 32'h1, 1'b0);
        wb(7, 32'h2, 1'b1);
        wb(6, 32'h3, 1'b0);
        chk("R6", "older commits", commit_valid, 4'b0001);
        chk("R6", "no fault yet", exc_valid, 0);
        tick();
        chk("R7", "exc_valid", exc_valid, 1);
        chk("R7", "exc_idx", exc_idx, 7);
        chk("R7", "flush", flush, 1);
        chk("R7", "no commit", commit_valid, 0);
        tick();
        chk("R7", "empty", empty, 1);
        chk("R7", "alloc_idx reset", alloc_idx, 0);
        chk("R7", "younger not committed", commit_valid, 0);
        chk("R7", "exc cleared", exc_valid, 0);
    endtask

    task automatic t_mispred();
        // head = 0, slots 0..4
        for (int k = 0; k < 5; k++) alloc(1'b0, DEST_W'(13 + k));
        wb(4, 32'h44, 1'b0);
        wb(3, 32'h43, 1'b0);
        wb(2, 32'h42, 1'b0);
        wb(1, 32'h41, 1'b0);
        wb(0, 32'h40, 1'b0);
        chk("R8", "group before cut", commit_valid, 4'b0111);
        mispred_valid = 1'b1;
        mispred_idx   = 3'd1;
        alloc_valid   = 1'b1;
        alloc_dest    = 5'd30;
        #0.2;
        chk("R8", "cut at branch", commit_valid, 4'b0011);
        tick();
        chk("R8", "younger discarded", empty, 1);
        chk("R8", "tail after branch", alloc_idx, 2);
        chk("R8", "no commit after", commit_valid, 0);
    endtask

    task automatic t_full();
        int total;
        logic bad;
        // head = tail = 2
        for (int k = 0; k < DEPTH; k++) alloc(1'b0, DEST_W'(20 + k));
        chk("R9", "full not ready", alloc_ready, 0);
        chk("R9", "not empty", empty, 0);
        alloc(1'b0, 5'd31);
        chk("R9", "refused keeps idx", alloc_idx, 2);
        for (int k = 1; k <= DEPTH; k++) wb((2 + DEPTH - k) % DEPTH, 32'(k), 1'b0);
        total = 0;
        bad   = 1'b0;
        for (int c = 0; c < 8; c++) begin
            total += $countones(commit_valid);
            for (int i = 0; i < MAX_RET; i++)
                if (commit_valid[i] && lane_dest(i) == 5'd31) bad = 1'b1;
            if (empty) break;
            tick();
        end
        chk("R9", "committed count", total, DEPTH);
        chk("R9", "refused entry absent", bad, 0);
        chk("R9", "drained", empty, 1);
    endtask

    initial begin
        #(4 * 20000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        #0.5;
        t_reset();
        t_order();
        t_ports();
        t_merge();
        t_fault();
        t_mispred();
        t_full();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule